// File: doc/BRIEF.md
# Redundant Sign-Bit Normalization Counter

This block takes a two's-complement operand and reports how many places it can be shifted left before its sign bit and the bit below it differ. It also returns the operand already shifted by that amount. A mode input selects the operand size. Wide mode uses all 32 bits. Narrow mode uses only the low 16 bits and ignores the upper bits of the input bus. Fixed-point datapaths use the block to scale a value to full precision before a multiply or divide, and keep the count so they can undo the scaling later.

Negative operands are bit-inverted before the count is taken, so the result counts redundant sign bits rather than leading zeros. Two operands have fixed results. Zero gives a count of 0. Minus one gives the largest count for the selected size.

With the default `REG_OUT = 1`, the count and the shifted value are registered. They appear one clock after an accepted input, with a one-cycle valid strobe. With `REG_OUT = 0` the path is purely combinational.

Top module: `signnorm_unit`

## Requirements
- R1: In wide mode (`in_wide` = 1) an input of 0x00000000 gives count 0 and shifted value 0x00000000.
- R2: In wide mode an input of 0xFFFFFFFF gives count 31 and shifted value 0x80000000.
- R3: In wide mode, for a non-negative nonzero input, the count is the number of left shifts needed to bring the value to at least 0x40000000 (for example 0x00000001 gives 30).
- R4: In wide mode, for a negative input other than minus one, the input is bit-inverted and then counted as in R3 (for example 0xFFFFFFFE gives 30 and 0x80000000 gives 0).
- R5: In narrow mode (`in_wide` = 0) only bits 15..0 are used. An operand of 0x0000 gives count 0, an operand of 0xFFFF gives count 15, and other operands are counted against 0x4000 after the same inversion of negatives.
- R6: In narrow mode, bits 31..16 of `in_data` have no effect on either output, bits 31..16 of `out_norm` are zero, and bits 15..0 of `out_norm` hold the 16-bit operand shifted left by the count.
- R7: In wide mode `out_norm` equals the input shifted left by the count. For every nonzero input, bit 31 and bit 30 of the shifted value differ, and in narrow mode bit 15 and bit 14 differ, so no overflow occurs.
- R8: With `REG_OUT` = 1, `out_valid` is high exactly one clock after each cycle with `in_valid` high. Count and shifted value update at that point and hold while `in_valid` is low. Synchronous `rst` clears `out_valid`, `out_count` and `out_norm` to zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operand present this cycle |
| in_wide | input | 1 | 1 = 32-bit operand, 0 = 16-bit operand in bits 15..0 |
| in_data | input | DATA_W | Operand |
| out_valid | output | 1 | Result strobe |
| out_count | output | $clog2(DATA_W) | Redundant sign-bit count |
| out_norm | output | DATA_W | Operand shifted left by the count |

## Verification
With the registered output stage, every result is due on the first rising edge after the cycle in which `in_valid` is high. The bench drives each operand on a falling edge. It then samples `out_valid`, `out_count` and `out_norm` on the following falling edge, half a period after the register has loaded. On the falling edge after that it confirms that the strobe has dropped and the result has held. Expected results come from a table of hand-worked cases and from a shift-loop model in the bench that is applied to a pseudo-random sweep in both modes.

// File: rtl/norm_pkg.sv
package norm_pkg;
  typedef enum logic {
    MODE_NARROW = 1'b0,
    MODE_WIDE   = 1'b1
  } width_mode_e;
endpackage

// File: rtl/norm_fold.sv
module norm_fold
  import norm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16
) (
  input  logic              mode_wide,
  input  logic [DATA_W-1:0] raw,
  output logic [DATA_W-1:0] aligned,
  output logic [DATA_W-1:0] folded,
  output logic              is_zero
);
  localparam int PAD_W = DATA_W - NARROW_W;

  // The narrow operand is placed in the top bits so that one datapath serves both sizes.
  always_comb begin
    if (width_mode_e'(mode_wide) == MODE_WIDE) begin
      aligned = raw;
      is_zero = (raw == '0);
    end else begin
      aligned = {raw[NARROW_W-1:0], {PAD_W{1'b0}}};
      is_zero = (raw[NARROW_W-1:0] == '0);
    end
  end

  // Drop the sign bit, invert negatives, and append a sentinel one so the count saturates at DATA_W-1.
  assign folded = {aligned[DATA_W-2:0] ^ {(DATA_W-1){aligned[DATA_W-1]}}, 1'b1};
endmodule

// File: rtl/norm_lzc.sv
module norm_lzc #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     z_in,
  output logic [CNT_W-1:0] lead
);
  logic [CNT_W:0][W-1:0] v;

  assign v[0] = z_in;

  // Each stage tests a window half the size of the previous one: 16, 8, 4, 2, 1.
  for (genvar s = 0; s < CNT_W; s++) begin : g_stage
    localparam int STEP = 1 << (CNT_W - 1 - s);
    logic hit;
    assign hit = (v[s][W-1 -: STEP] == '0);
    assign lead[CNT_W-1-s] = hit;
    assign v[s+1] = hit ? (v[s] << STEP) : v[s];
  end

  // After all the counted shifts, the leading one must sit in the top bit.
  always_comb begin
    if (!$isunknown(z_in)) begin
      assert_lead_one_R3: assert (v[CNT_W][W-1] == 1'b1 && v[CNT_W] != '0);
    end
  end
endmodule

// File: rtl/norm_shift.sv
module norm_shift #(
  parameter int W     = 32,
  parameter int CNT_W = $clog2(W)
) (
  input  logic [W-1:0]     d_in,
  input  logic [CNT_W-1:0] amount,
  output logic [W-1:0]     d_out
);
  logic [CNT_W:0][W-1:0] sh;

  assign sh[0] = d_in;

  for (genvar k = 0; k < CNT_W; k++) begin : g_lvl
    assign sh[k+1] = amount[k] ? (sh[k] << (1 << k)) : sh[k];
  end

  assign d_out = sh[CNT_W];
endmodule

// File: rtl/signnorm_unit.sv
module signnorm_unit
  import norm_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NARROW_W = 16,
  parameter bit REG_OUT  = 1'b1,
  localparam int CNT_W   = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  input  logic              in_wide,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  output logic [CNT_W-1:0]  out_count,
  output logic [DATA_W-1:0] out_norm
);
  localparam int PAD_W = DATA_W - NARROW_W;

  logic [DATA_W-1:0] aligned_w, folded_w, shifted_w;
  logic              zero_w;
  logic [CNT_W-1:0]  lead_w, cnt_c;
  logic [DATA_W-1:0] norm_c;

  norm_fold #(.DATA_W(DATA_W), .NARROW_W(NARROW_W)) fold_i (
    .mode_wide (in_wide),
    .raw       (in_data),
    .aligned   (aligned_w),
    .folded    (folded_w),
    .is_zero   (zero_w)
  );

  norm_lzc #(.W(DATA_W), .CNT_W(CNT_W)) lzc_i (
    .z_in (folded_w),
    .lead (lead_w)
  );

  // Zero has no leading one and is pinned to zero. Minus one already counts to the maximum via the sentinel.
  assign cnt_c = zero_w ? '0 : lead_w;

  norm_shift #(.W(DATA_W), .CNT_W(CNT_W)) shift_i (
    .d_in   (aligned_w),
    .amount (cnt_c),
    .d_out  (shifted_w)
  );

  assign norm_c = (width_mode_e'(in_wide) == MODE_WIDE) ? shifted_w
                : {{PAD_W{1'b0}}, shifted_w[DATA_W-1 -: NARROW_W]};

  if (REG_OUT) begin : g_reg
    logic              valid_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [DATA_W-1:0] norm_q;

    always_ff @(posedge clk) begin
      if (rst) begin
        valid_q <= 1'b0;
        cnt_q   <= '0;
        norm_q  <= '0;
      end else begin
        valid_q <= in_valid;
        if (in_valid) begin
          cnt_q  <= cnt_c;
          norm_q <= norm_c;
        end
      end
    end

    assign out_valid = valid_q;
    assign out_count = cnt_q;
    assign out_norm  = norm_q;

    assert_strobe_R8: assert property (@(posedge clk) disable iff (rst)
      in_valid |=> out_valid);
    assert_idle_R8: assert property (@(posedge clk) disable iff (rst)
      !in_valid |=> (!out_valid && $stable(out_count) && $stable(out_norm)));
    assert_zero_R1: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_wide && in_data == '0) |=> (out_count == '0 && out_norm == '0));
    assert_minus_one_R2: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_wide && in_data == '1) |=> (out_count == CNT_W'(DATA_W-1)));
    assert_no_overflow_R7: assert property (@(posedge clk) disable iff (rst)
      (in_valid && in_wide && in_data != '0) |=> (out_norm[DATA_W-1] != out_norm[DATA_W-2]));
    assert_narrow_fit_R6: assert property (@(posedge clk) disable iff (rst)
      (in_valid && !in_wide && in_data[NARROW_W-1:0] != '0) |=>
        (out_norm[DATA_W-1:NARROW_W] == '0 && out_norm[NARROW_W-1] != out_norm[NARROW_W-2]));
  end else begin : g_comb
    assign out_valid = in_valid;
    assign out_count = cnt_c;
    assign out_norm  = norm_c;
  end
endmodule

// File: tb/signnorm_unit_tb.sv
module signnorm_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic        in_wide;
  logic [31:0] in_data;
  logic        out_valid;
  logic [4:0]  out_count;
  logic [31:0] out_norm;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #5 clk = ~clk;

  signnorm_unit #(.DATA_W(32), .NARROW_W(16), .REG_OUT(1'b1)) dut_i (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_wide(in_wide),
    .in_data(in_data), .out_valid(out_valid), .out_count(out_count), .out_norm(out_norm)
  );

  typedef struct packed {
    logic [3:0]  tag;
    logic        wide;
    logic [31:0] data;
    logic [4:0]  cnt;
    logic [31:0] norm;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VECS [NV] = '{
    '{4'd1, 1'b1, 32'h00000000, 5'd0,  32'h00000000},  // R1
    '{4'd2, 1'b1, 32'hFFFFFFFF, 5'd31, 32'h80000000},  // R2
    '{4'd3, 1'b1, 32'h00000001, 5'd30, 32'h40000000},  // R3
    '{4'd3, 1'b1, 32'h40000000, 5'd0,  32'h40000000},  // R3
    '{4'd3, 1'b1, 32'h7FFFFFFF, 5'd0,  32'h7FFFFFFF},  // R3
    '{4'd3, 1'b1, 32'h00012345, 5'd14, 32'h48D14000},  // R3
    '{4'd4, 1'b1, 32'h80000000, 5'd0,  32'h80000000},  // R4
    '{4'd4, 1'b1, 32'hFFFFFFFE, 5'd30, 32'h80000000},  // R4
    '{4'd4, 1'b1, 32'hC0000000, 5'd1,  32'h80000000},  // R4
    '{4'd4, 1'b1, 32'hFFFF8000, 5'd16, 32'h80000000},  // R4
    '{4'd5, 1'b0, 32'h00000000, 5'd0,  32'h00000000},  // R5
    '{4'd5, 1'b0, 32'h0000FFFF, 5'd15, 32'h00008000},  // R5
    '{4'd5, 1'b0, 32'h00000001, 5'd14, 32'h00004000},  // R5
    '{4'd6, 1'b0, 32'hABCD8000, 5'd0,  32'h00008000},  // R6
    '{4'd6, 1'b0, 32'h12340F00, 5'd3,  32'h00007800},  // R6
    '{4'd5, 1'b0, 32'h0000FFF0, 5'd11, 32'h00008000},  // R5
    '{4'd6, 1'b0, 32'hFFFF0000, 5'd0,  32'h00000000}   // R6
  };

  function automatic string tag_name(input int t);
    case (t)
      1: return "R1";
      2: return "R2";
      3: return "R3";
      4: return "R4";
      5: return "R5";
      6: return "R6";
      7: return "R7";
      default: return "R8";
    endcase
  endfunction

  // Shift-loop model written from the requirements.
  function automatic void model(input bit wide, input logic [31:0] d,
                                output int cnt, output logic [31:0] nrm);
    int     w;
    longint v, t, lim, s;
    w = wide ? 32 : 16;
    v = wide ? longint'($signed(d)) : longint'($signed(d[15:0]));
    if (v == 0) cnt = 0;
    else if (v == -1) cnt = w - 1;
    else begin
      t   = (v < 0) ? ~v : v;
      lim = longint'(1) << (w - 2);
      cnt = 0;
      while (t < lim) begin t = t << 1; cnt++; end
    end
    s   = v <<< cnt;
    nrm = wide ? s[31:0] : {16'h0000, s[15:0]};
  endfunction

  task automatic check(input string tag, input string what, input longint act, input longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  // Result is loaded at the posedge after the driving negedge and sampled on the next negedge.
  task automatic apply(input string tag, input bit wide, input logic [31:0] d,
                       input int ecnt, input logic [31:0] enorm);
    @(negedge clk);
    in_valid = 1'b1; in_wide = wide; in_data = d;
    @(negedge clk);
    in_valid = 1'b0; in_data = ~d; in_wide = ~wide;
    check("R8", "out_valid", longint'(out_valid), 1);
    check(tag, "count", longint'(out_count), longint'(ecnt));
    check(tag, "norm", longint'(out_norm), longint'(enorm));
    if (enorm != 0) begin
      if (wide) check("R7", "top bits differ", longint'(out_norm[31] ^ out_norm[30]), 1);
      else      check("R7", "top bits differ", longint'(out_norm[15] ^ out_norm[14]), 1);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL R8 watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    int          mc;
    logic [31:0] mn;
    logic [31:0] lfsr;
    rst = 1'b1; in_valid = 1'b0; in_wide = 1'b1; in_data = 32'h0;
    repeat (3) @(negedge clk);
    check("R8", "reset valid", longint'(out_valid), 0);
    check("R8", "reset count", longint'(out_count), 0);
    check("R8", "reset norm", longint'(out_norm), 0);
    rst = 1'b0;

    for (int i = 0; i < NV; i++)
      apply(tag_name(int'(VECS[i].tag)), VECS[i].wide, VECS[i].data,
            int'(VECS[i].cnt), VECS[i].norm);

    // R8: strobe drops and the result holds while in_valid is low
    apply("R3", 1'b1, 32'h00000100, 22, 32'h40000000);
    @(negedge clk);
    check("R8", "strobe low", longint'(out_valid), 0);
    check("R8", "count held", longint'(out_count), 22);
    check("R8", "norm held", longint'(out_norm), 32'h40000000);

    // R6: narrow result independent of upper input bits
    apply("R6", 1'b0, 32'h00000123, 6, 32'h000048C0);
    apply("R6", 1'b0, 32'hFFFF0123, 6, 32'h000048C0);

    // R3 R4 R5 R7: sweep against the model in both modes
    lfsr = 32'hACE1_2468;
    for (int k = 0; k < 400; k++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      mc = 0; mn = '0;
      model(k[0], lfsr >> (k % 29), mc, mn);
      apply(k[0] ? "R4" : "R5", k[0], lfsr >> (k % 29), mc, mn);
    end

    // R8: reset mid-stream clears the outputs
    @(negedge clk);
    in_valid = 1'b1; in_wide = 1'b1; in_data = 32'h1;
    rst = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b0;
    check("R8", "reset-over-valid", longint'(out_valid), 0);
    check("R8", "reset-over-count", longint'(out_count), 0);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule